// File: doc/BRIEF.md
# Scan-Chain Debug Register Access Unit

This block is the data register that sits behind a debug instruction on a JTAG-style test port. It lets an external debugger reach a small bank of debug registers on the target: a debug control word, a debug status word, a vector-catch mask, two watchpoint units with value and mask words, and a two-way communications channel between debugger and processor with one ready flag per direction. The TAP state machine is outside the block. It supplies one-cycle capture, shift and update strobes in the block's clock domain, together with the serial input, and it takes the serial output.

Each scan moves a 38-bit frame. On update, a frame with the direction bit set writes its data field into the addressed register. A frame with the direction bit clear takes a snapshot of the addressed register, and that snapshot is shifted out during the next scan. Reading the comms data register hands its word to the debugger and clears the matching flag. A debugger that reads several words should therefore address the comms control register in its final scan, so that it does not consume an extra word. The processor reaches the same bank through a simple synchronous read/write port. Through that port it writes words to the debugger, takes words from the debugger and reports its status.

Top module: `dbg_scan_regs`

## Requirements
- R1: The frame is 38 bits and shifts in and out least significant bit first. Bits 31:0 are the data field, bits 36:32 the address and bit 37 the direction. A capture loads bits 37:32 with zero, and `tdo_o` shows frame bit 0 until the first shift.
- R2: On an update strobe with direction 1, the data field is written into the addressed host-writable register.
- R3: On an update strobe with direction 0, the addressed register is snapshotted. The next capture loads that snapshot into the data field. Write scans leave the snapshot unchanged.
- R4: Address map. 0x00 is the 6-bit debug control register and 0x02 the 8-bit vector catch (`VCATCH_W`). 0x01 is the 5-bit status register, and host writes to it are ignored. 0x04 is comms control and 0x05 comms data. Watchpoint k (k = 0, 1) has six 32-bit words at 8*(k+1)+0 to 8*(k+1)+5. Every other address reads zero and ignores writes. Bits above a register's width read zero.
- R5: Comms control reads bit 0 as read-ready (a host word is pending for the processor) and bit 1 as write-ready (a processor word is pending for the host). Bits 27:2 read zero and bits 31:28 read `VERSION` (default 6). Writes to this register are ignored.
- R6: A host read scan of 0x05 snapshots the processor-to-host word and clears write-ready. A read scan of 0x04 changes no flag.
- R7: A host write scan of 0x05 stores the word for the processor and sets read-ready. A second write before the processor takes the word overwrites it.
- R8: Processor port. A write to 0x05 stores the word for the host and sets write-ready. A write to 0x01 loads the status register. Processor writes to any other address are ignored. `cpu_rdata_o` shows the register read one cycle after `cpu_re_i`. It gives the host word at 0x05, and reading 0x05 clears read-ready. At every other address it gives the value the host would see.
- R9: `dbg_ctrl_o` and `vcatch_o` show the debug control and vector catch registers. Bit 4 of debug control is the monitor-mode enable, and software clears it by writing 0 there.
- R10: A synchronous active-high reset clears the control, status and vector-catch registers, both comms words, both flags and the read snapshot. Watchpoint storage is not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_i | input | 1 | Capture strobe from the TAP, one cycle |
| shf_i | input | 1 | Shift strobe, one bit per cycle |
| upd_i | input | 1 | Update strobe, one cycle |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out (frame bit 0) |
| cpu_addr_i | input | 5 | Processor port register address |
| cpu_we_i | input | 1 | Processor write enable |
| cpu_re_i | input | 1 | Processor read enable |
| cpu_wdata_i | input | 32 | Processor write data |
| cpu_rdata_o | output | 32 | Processor read data, valid one cycle after read |
| dbg_ctrl_o | output | 6 | Debug control register |
| vcatch_o | output | 8 | Vector catch register |

## Verification
The assertions assume that the TAP asserts at most one of capture, shift and update in any cycle. They also assume that an update follows a complete 38-bit shift, so the address and direction fields hold a real frame when the update strobe fires. The flag properties allow for a processor access and a host update to the same comms register in one cycle, and they only check the case where the two do not collide. The bench drives each scan as a capture cycle, then 38 shift cycles, then an update cycle, and it never overlaps a processor access to 0x05 with an update, so its inputs stay within those assumptions.

// File: rtl/dbg_scan_pkg.sv
`timescale 1ns/1ps
package dbg_scan_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 5;
  localparam int FRAME_W = DATA_W + ADDR_W + 1;

  localparam logic [ADDR_W-1:0] A_CTRL   = 5'h00;
  localparam logic [ADDR_W-1:0] A_STAT   = 5'h01;
  localparam logic [ADDR_W-1:0] A_VCATCH = 5'h02;
  localparam logic [ADDR_W-1:0] A_CCTRL  = 5'h04;
  localparam logic [ADDR_W-1:0] A_CDATA  = 5'h05;

  // words per watchpoint unit and address stride between units
  localparam int WP_WORDS = 6;
  localparam int WP_STRIDE_LOG = 3;
endpackage

// File: rtl/dbg_shift_chain.sv
`timescale 1ns/1ps
module dbg_shift_chain #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_i,
  input  logic              shf_i,
  input  logic              tdi_i,
  input  logic [DATA_W-1:0] cap_data_i,
  output logic              tdo_o,
  output logic [DATA_W-1:0] fr_data_o,
  output logic [ADDR_W-1:0] fr_addr_o,
  output logic              fr_dir_o
);
  localparam int FRAME_W = DATA_W + ADDR_W + 1;

  logic [FRAME_W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
    end else if (cap_i) begin
      sr_q <= {{(ADDR_W+1){1'b0}}, cap_data_i};
    end else if (shf_i) begin
      sr_q <= {tdi_i, sr_q[FRAME_W-1:1]};
    end
  end

  assign tdo_o     = sr_q[0];
  assign fr_data_o = sr_q[DATA_W-1:0];
  assign fr_addr_o = sr_q[DATA_W +: ADDR_W];
  assign fr_dir_o  = sr_q[FRAME_W-1];
endmodule

// File: rtl/dbg_comms_chan.sv
`timescale 1ns/1ps
module dbg_comms_chan #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              h_wr_i,
  input  logic [DATA_W-1:0] h_wdata_i,
  input  logic              h_take_i,
  input  logic              c_wr_i,
  input  logic [DATA_W-1:0] c_wdata_i,
  input  logic              c_take_i,
  output logic [DATA_W-1:0] h2c_word_o,
  output logic [DATA_W-1:0] c2h_word_o,
  output logic              rd_ready_o,
  output logic              wr_ready_o
);
  // host -> processor direction; a new word wins over a same-cycle take
  always_ff @(posedge clk) begin
    if (rst) begin
      h2c_word_o <= '0;
      rd_ready_o <= 1'b0;
    end else if (h_wr_i) begin
      h2c_word_o <= h_wdata_i;
      rd_ready_o <= 1'b1;
    end else if (c_take_i) begin
      rd_ready_o <= 1'b0;
    end
  end

  // processor -> host direction
  always_ff @(posedge clk) begin
    if (rst) begin
      c2h_word_o <= '0;
      wr_ready_o <= 1'b0;
    end else if (c_wr_i) begin
      c2h_word_o <= c_wdata_i;
      wr_ready_o <= 1'b1;
    end else if (h_take_i) begin
      wr_ready_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dbg_wp_bank.sv
`timescale 1ns/1ps
module dbg_wp_bank #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              hre_i,
  input  logic [IDX_W-1:0]  haddr_i,
  output logic [DATA_W-1:0] hq_o,
  input  logic              cre_i,
  input  logic [IDX_W-1:0]  caddr_i,
  output logic [DATA_W-1:0] cq_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (hre_i) hq_o <= mem_q[haddr_i];
  end

  always_ff @(posedge clk) begin
    if (cre_i) cq_o <= mem_q[caddr_i];
  end
endmodule

// File: rtl/dbg_scan_regs.sv
`timescale 1ns/1ps
module dbg_scan_regs
  import dbg_scan_pkg::*;
#(
  parameter int         NUM_WP   = 2,
  parameter int         CTRL_W   = 6,
  parameter int         STAT_W   = 5,
  parameter int         VCATCH_W = 8,
  parameter logic [3:0] VERSION  = 4'd6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_i,
  input  logic              shf_i,
  input  logic              upd_i,
  input  logic              tdi_i,
  output logic              tdo_o,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic              cpu_we_i,
  input  logic              cpu_re_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic [CTRL_W-1:0] dbg_ctrl_o,
  output logic [VCATCH_W-1:0] vcatch_o
);
  localparam int UNIT_W = (NUM_WP > 1) ? $clog2(NUM_WP) : 1;
  localparam int IDX_W  = UNIT_W + WP_STRIDE_LOG;
  localparam int UNIT_HI = ADDR_W - WP_STRIDE_LOG;

  logic [DATA_W-1:0] fr_data;
  logic [ADDR_W-1:0] fr_addr;
  logic              fr_dir;
  logic [DATA_W-1:0] cap_data;

  logic [CTRL_W-1:0]   ctrl_q;
  logic [STAT_W-1:0]   stat_q;
  logic [VCATCH_W-1:0] vc_q;
  logic [DATA_W-1:0]   rd_loc_q, cpu_loc_q;
  logic                rd_wp_q, cpu_wp_q;
  logic [DATA_W-1:0]   wp_hq, wp_cq;
  logic [DATA_W-1:0]   h2c_word, c2h_word;
  logic                rd_ready, wr_ready;

  function automatic logic wp_hit(input logic [ADDR_W-1:0] a);
    logic [UNIT_HI-1:0] u;
    u = a[ADDR_W-1:WP_STRIDE_LOG];
    return (u != '0) && (int'(u) <= NUM_WP) &&
           (int'(a[WP_STRIDE_LOG-1:0]) < WP_WORDS);
  endfunction

  function automatic logic [IDX_W-1:0] wp_idx(input logic [ADDR_W-1:0] a);
    logic [UNIT_HI-1:0] u;
    u = a[ADDR_W-1:WP_STRIDE_LOG] - 1'b1;
    return {u[UNIT_W-1:0], a[WP_STRIDE_LOG-1:0]};
  endfunction

  // value of a non-watchpoint register; cdata picks the side-specific word
  function automatic logic [DATA_W-1:0] loc_read(input logic [ADDR_W-1:0] a,
                                                 input logic [DATA_W-1:0] cdata);
    logic [DATA_W-1:0] v;
    v = '0;
    case (a)
      A_CTRL:   v[CTRL_W-1:0]   = ctrl_q;
      A_STAT:   v[STAT_W-1:0]   = stat_q;
      A_VCATCH: v[VCATCH_W-1:0] = vc_q;
      A_CCTRL:  v = {VERSION, {(DATA_W-6){1'b0}}, wr_ready, rd_ready};
      A_CDATA:  v = cdata;
      default:  v = '0;
    endcase
    return v;
  endfunction

  wire h_wr = upd_i & fr_dir;
  wire h_rd = upd_i & ~fr_dir;
  wire h_wp = wp_hit(fr_addr);
  wire c_wp = wp_hit(cpu_addr_i);

  dbg_shift_chain #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chain_i (
    .clk(clk), .rst(rst), .cap_i(cap_i), .shf_i(shf_i), .tdi_i(tdi_i),
    .cap_data_i(cap_data), .tdo_o(tdo_o),
    .fr_data_o(fr_data), .fr_addr_o(fr_addr), .fr_dir_o(fr_dir)
  );

  dbg_comms_chan #(.DATA_W(DATA_W)) comms_i (
    .clk(clk), .rst(rst),
    .h_wr_i(h_wr && fr_addr == A_CDATA), .h_wdata_i(fr_data),
    .h_take_i(h_rd && fr_addr == A_CDATA),
    .c_wr_i(cpu_we_i && cpu_addr_i == A_CDATA), .c_wdata_i(cpu_wdata_i),
    .c_take_i(cpu_re_i && cpu_addr_i == A_CDATA),
    .h2c_word_o(h2c_word), .c2h_word_o(c2h_word),
    .rd_ready_o(rd_ready), .wr_ready_o(wr_ready)
  );

  dbg_wp_bank #(.DATA_W(DATA_W), .IDX_W(IDX_W)) wp_i (
    .clk(clk),
    .we_i(h_wr && h_wp), .waddr_i(wp_idx(fr_addr)), .wdata_i(fr_data),
    .hre_i(h_rd && h_wp), .haddr_i(wp_idx(fr_addr)), .hq_o(wp_hq),
    .cre_i(cpu_re_i && c_wp), .caddr_i(wp_idx(cpu_addr_i)), .cq_o(wp_cq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      stat_q    <= '0;
      vc_q      <= '0;
      rd_loc_q  <= '0;
      rd_wp_q   <= 1'b0;
      cpu_loc_q <= '0;
      cpu_wp_q  <= 1'b0;
    end else begin
      if (h_wr && fr_addr == A_CTRL)   ctrl_q <= fr_data[CTRL_W-1:0];
      if (h_wr && fr_addr == A_VCATCH) vc_q   <= fr_data[VCATCH_W-1:0];
      if (cpu_we_i && cpu_addr_i == A_STAT) stat_q <= cpu_wdata_i[STAT_W-1:0];
      if (h_rd) begin
        rd_loc_q <= loc_read(fr_addr, c2h_word);
        rd_wp_q  <= h_wp;
      end
      if (cpu_re_i) begin
        cpu_loc_q <= loc_read(cpu_addr_i, h2c_word);
        cpu_wp_q  <= c_wp;
      end
    end
  end

  assign cap_data    = rd_wp_q ? wp_hq : rd_loc_q;
  assign cpu_rdata_o = cpu_wp_q ? wp_cq : cpu_loc_q;
  assign dbg_ctrl_o  = ctrl_q;
  assign vcatch_o    = vc_q;
endmodule

// File: rtl/dbg_scan_regs_chk.sv
`timescale 1ns/1ps
module dbg_scan_regs_chk
  import dbg_scan_pkg::*;
#(
  parameter logic [3:0] VERSION = 4'd6,
  parameter int         CTRL_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              upd,
  input logic              dir,
  input logic [ADDR_W-1:0] addr,
  input logic              cpu_we,
  input logic              cpu_re,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              rd_ready,
  input logic              wr_ready,
  input logic [CTRL_W-1:0] ctrl
);
  p_host_take_r6: assert property (@(posedge clk) disable iff (rst)
    (upd && !dir && addr == A_CDATA && !(cpu_we && cpu_addr == A_CDATA)) |=> !wr_ready);

  p_host_put_r7: assert property (@(posedge clk) disable iff (rst)
    (upd && dir && addr == A_CDATA) |=> rd_ready);

  p_cpu_take_r8: assert property (@(posedge clk) disable iff (rst)
    (cpu_re && cpu_addr == A_CDATA && !(upd && dir && addr == A_CDATA)) |=> !rd_ready);

  p_ctrl_width_r4: assert property (@(posedge clk) disable iff (rst)
    (cpu_re && cpu_addr == A_CTRL) |=> (cpu_rdata[DATA_W-1:CTRL_W] == '0));

  p_cctrl_fields_r5: assert property (@(posedge clk) disable iff (rst)
    (cpu_re && cpu_addr == A_CCTRL) |=>
      (cpu_rdata[27:2] == '0 && cpu_rdata[31:28] == VERSION));

  p_reset_clear_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rd_ready && !wr_ready && ctrl == '0));
endmodule

bind dbg_scan_regs dbg_scan_regs_chk #(.VERSION(VERSION), .CTRL_W(CTRL_W)) chk_i (
  .clk(clk), .rst(rst), .upd(upd_i), .dir(fr_dir), .addr(fr_addr),
  .cpu_we(cpu_we_i), .cpu_re(cpu_re_i), .cpu_addr(cpu_addr_i),
  .cpu_rdata(cpu_rdata_o), .rd_ready(rd_ready), .wr_ready(wr_ready),
  .ctrl(dbg_ctrl_o)
);

// File: tb/dbg_scan_regs_tb_top.sv
`timescale 1ns/1ps
module dbg_scan_regs_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cap = 1'b0, shf = 1'b0, upd = 1'b0, tdi = 1'b0;
  logic tdo;
  logic [4:0]  cpu_addr = '0;
  logic        cpu_we = 1'b0, cpu_re = 1'b0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic [5:0]  dbg_ctrl;
  logic [7:0]  vcatch;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dbg_scan_regs dut_i (
    .clk(clk), .rst(rst), .cap_i(cap), .shf_i(shf), .upd_i(upd), .tdi_i(tdi),
    .tdo_o(tdo), .cpu_addr_i(cpu_addr), .cpu_we_i(cpu_we), .cpu_re_i(cpu_re),
    .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata),
    .dbg_ctrl_o(dbg_ctrl), .vcatch_o(vcatch)
  );

  typedef struct packed {
    logic        dir;
    logic [4:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  // expected = data field captured at the start of that scan
  localparam vec_t VEC [24] = '{
    '{1'b1, 5'h00, 32'hFFFFFFFF, 32'h00000000},
    '{1'b0, 5'h00, 32'h0,        32'h00000000},
    '{1'b0, 5'h02, 32'h0,        32'h0000003F},
    '{1'b1, 5'h02, 32'h123456A5, 32'h00000000},
    '{1'b0, 5'h02, 32'h0,        32'h00000000},
    '{1'b1, 5'h08, 32'hDEADBEEF, 32'h000000A5},
    '{1'b1, 5'h15, 32'h0BADF00D, 32'h000000A5},
    '{1'b0, 5'h08, 32'h0,        32'h000000A5},
    '{1'b0, 5'h15, 32'h0,        32'hDEADBEEF},
    '{1'b1, 5'h0E, 32'hFFFFFFFF, 32'h0BADF00D},
    '{1'b0, 5'h0E, 32'h0,        32'h0BADF00D},
    '{1'b0, 5'h04, 32'h0,        32'h00000000},
    '{1'b1, 5'h01, 32'h0000001F, 32'h60000000},
    '{1'b0, 5'h01, 32'h0,        32'h60000000},
    '{1'b0, 5'h03, 32'h0,        32'h00000000},
    '{1'b0, 5'h00, 32'h0,        32'h00000000},
    '{1'b1, 5'h00, 32'h0000002F, 32'h0000003F},
    '{1'b0, 5'h00, 32'h0,        32'h0000003F},
    '{1'b0, 5'h18, 32'h0,        32'h0000002F},
    '{1'b0, 5'h04, 32'h0,        32'h00000000},
    '{1'b1, 5'h10, 32'h11111111, 32'h60000000},
    '{1'b0, 5'h08, 32'h0,        32'h60000000},
    '{1'b0, 5'h10, 32'h0,        32'hDEADBEEF},
    '{1'b0, 5'h00, 32'h0,        32'h11111111}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic scan(input logic dir, input logic [4:0] addr,
                      input logic [31:0] data, output logic [37:0] got);
    logic [37:0] frame;
    frame = {dir, addr, data};
    @(negedge clk); cap = 1'b1;
    @(negedge clk); cap = 1'b0;
    for (int i = 0; i < 38; i++) begin
      got[i] = tdo;
      tdi = frame[i];
      shf = 1'b1;
      @(negedge clk);
    end
    shf = 1'b0; upd = 1'b1;
    @(negedge clk); upd = 1'b0;
  endtask

  task automatic cpu_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk); cpu_we = 1'b0;
  endtask

  task automatic cpu_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); cpu_addr = a; cpu_re = 1'b1;
    @(negedge clk); cpu_re = 1'b0; d = cpu_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [37:0] g;
    logic [31:0] r;
    do_reset();

    // reset state
    check("R10 ctrl after reset", 64'(dbg_ctrl), 64'h0);
    check("R10 vcatch after reset", 64'(vcatch), 64'h0);
    cpu_read(5'h04, r);
    check("R5 R10 comms ctrl after reset", 64'(r), 64'h60000000);

    // table walk
    for (int i = 0; i < 24; i++) begin
      scan(VEC[i].dir, VEC[i].addr, VEC[i].data, g);
      check($sformatf("R1 R2 R3 R4 vector %0d", i), 64'(g), {32'h0, VEC[i].exp});
    end
    check("R9 ctrl output, monitor bit cleared", 64'(dbg_ctrl), 64'h2F);
    check("R9 vcatch output", 64'(vcatch), 64'hA5);

    // host -> processor
    scan(1'b1, 5'h05, 32'hAAAA0001, g);
    cpu_read(5'h04, r);
    check("R7 read-ready set", 64'(r), 64'h60000001);
    scan(1'b1, 5'h05, 32'hAAAA0002, g);
    cpu_read(5'h05, r);
    check("R7 R8 overwritten host word", 64'(r), 64'hAAAA0002);
    cpu_read(5'h04, r);
    check("R8 read-ready cleared by take", 64'(r), 64'h60000000);

    // processor -> host
    cpu_write(5'h05, 32'hC0DE0001);
    cpu_read(5'h04, r);
    check("R8 write-ready set", 64'(r), 64'h60000002);
    scan(1'b0, 5'h05, 32'h0, g);
    scan(1'b0, 5'h04, 32'h0, g);
    check("R6 word read by host", 64'(g), 64'hC0DE0001);
    scan(1'b0, 5'h04, 32'h0, g);
    check("R6 write-ready cleared by read", 64'(g), 64'h60000000);

    // control read consumes nothing
    cpu_write(5'h05, 32'hC0DE0002);
    scan(1'b0, 5'h04, 32'h0, g);
    scan(1'b0, 5'h04, 32'h0, g);
    check("R6 control read shows pending", 64'(g), 64'h60000002);
    cpu_read(5'h04, r);
    check("R6 control read keeps word", 64'(r), 64'h60000002);
    scan(1'b0, 5'h05, 32'h0, g);
    scan(1'b0, 5'h04, 32'h0, g);
    check("R6 second word", 64'(g), 64'hC0DE0002);
    cpu_read(5'h04, r);
    check("R6 one read takes one word", 64'(r), 64'h60000000);

    // processor port: ignored writes, status, watchpoint read
    cpu_write(5'h00, 32'h0000003F);
    check("R8 processor write to ctrl ignored", 64'(dbg_ctrl), 64'h2F);
    cpu_write(5'h01, 32'hFFFFFFFF);
    cpu_read(5'h01, r);
    check("R8 status width", 64'(r), 64'h1F);
    scan(1'b0, 5'h01, 32'h0, g);
    scan(1'b0, 5'h00, 32'h0, g);
    check("R4 status seen by host", 64'(g), 64'h1F);
    cpu_read(5'h15, r);
    check("R8 watchpoint via processor", 64'(r), 64'h0BADF00D);
    cpu_read(5'h18, r);
    check("R4 unmapped via processor", 64'(r), 64'h0);

    // mid-run reset
    do_reset();
    check("R10 ctrl cleared", 64'(dbg_ctrl), 64'h0);
    check("R10 vcatch cleared", 64'(vcatch), 64'h0);
    cpu_read(5'h01, r);
    check("R10 status cleared", 64'(r), 64'h0);
    cpu_read(5'h05, r);
    check("R10 host word cleared", 64'(r), 64'h0);
    scan(1'b0, 5'h04, 32'h0, g);
    check("R10 read snapshot cleared", 64'(g), 64'h0);
    scan(1'b0, 5'h05, 32'h0, g);
    check("R5 R10 flags cleared", 64'(g), 64'h60000000);
    scan(1'b0, 5'h00, 32'h0, g);
    check("R10 processor word cleared", 64'(g), 64'h0);

    finish_run();
  end
endmodule